// File: doc/BRIEF.md
# Backplane Timing Word Decoder

This block sits on the external bus of a waveform sequencer processor that writes one word every cycle. Each accepted word does one of three jobs. It can stall the writer for a programmed number of 50 ns steps. It can load a register of direct digital control lines that drive the backplane. It can write a value into one DAC on one of many analog cards. One instance models the logic of one analog card together with the locally intercepted control-line register. The card's DACs are modelled as registers whose contents appear on flattened output buses.

A DAC word carries a 5-bit board select, a 4-bit DAC code and an 8-bit value. The board select is built from four data bits and one address line. A word is acted on when its select equals the card's strapped address. One fixed select code never reaches a card and loads the control lines instead. Twelve DAC codes write the 8-bit clock DACs directly. One further code drives a two-step sequence for the eight 12-bit bias DACs. The first step chooses which bias DAC to load, and the second step supplies the value, which is stored left-justified with the low four bits zero.

Top module: `bpTimingDecoder`

## Requirements
- R1: After reset, `ctrlLines`, `clkDacBus` and `biasDacBus` are all zero, no bias step is pending, and `waitOut` is low.
- R2: A delay word (`wrEn` and `wrDelay` high) holds a step count N in `busData[7:0]`. A count of 0 is taken as 1 and a count above 250 is taken as 250. `waitOut` goes high combinationally in the cycle the word is presented and stays high for exactly N*TICK_CYCLES cycles, counting that cycle.
- R3: Any word presented while `waitOut` is high because of an earlier delay word is ignored. It does not reload the delay and does not change any register or pending state.
- R4: For a non-delay word, the board select is {`busData[15:12]`, `busA0`}, with `busA0` as the least significant bit. A word whose select matches neither `cardAddr` nor the control-line code changes no output.
- R5: A non-delay word whose select equals CTRL_CODE (default 5'h1F) loads `busData[7:0]` into `ctrlLines` on the next edge, whatever `cardAddr` is.
- R6: A card word whose DAC code `busData[11:8]` is 0 to 11 writes `busData[7:0]` into clock DAC k. Clock DAC k appears at `clkDacBus[8k+7:8k]`.
- R7: A card word with DAC code BIAS_CODE (default 12) and no pending step latches the bias index `busData[2:0]` and leaves every DAC unchanged.
- R8: A card word with DAC code BIAS_CODE while a step is pending writes {`busData[7:0]`, 4'b0000} into the latched bias DAC j, which appears at `biasDacBus[12j+11:12j]`, and clears the pending step.
- R9: A card word with any DAC code other than BIAS_CODE cancels a pending step. That word still performs its own action, and codes 13 to 15 have no other effect.
- R10: Delay words, control-line words and words for other boards leave a pending bias step intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | A bus word is presented this cycle |
| wrDelay | input | 1 | The presented word is a delay word |
| busData | input | 16 | Bus data word |
| busA0 | input | 1 | Address line forming the select LSB |
| cardAddr | input | 5 | Strapped card address |
| waitOut | output | 1 | Stall request to the writer |
| ctrlLines | output | 8 | Direct control-line register |
| clkDacBus | output | 96 | Twelve 8-bit clock DAC values |
| biasDacBus | output | 96 | Eight 12-bit bias DAC values |

## Verification
The hardest state to reach is a pending first bias step that survives interleaved traffic, such as delays, control-line updates and words for other cards, and is then either completed or cancelled. Random traffic seldom produces two matching bias words on the right card with only harmless words in between. The stimulus therefore weights the board select toward the local card and the DAC code toward the bias code, and directed sequences place a delay and a foreign word between the two steps. Delay clamping at counts of 0, 250 and 255 and words arriving during a stall are driven directly.

// File: rtl/bpDecodePkg.sv
package bpDecodePkg;
  localparam int VAL_W    = 8;   // value field width
  localparam int CODE_W   = 4;   // DAC code field width
  localparam int SEL_W    = 5;   // board select width
  localparam int BIDX_W   = 3;   // bias index width
  localparam int N_BIAS   = 1 << BIDX_W;
  localparam int BIAS_W   = 12;  // bias DAC width
  localparam int PAD_W    = BIAS_W - VAL_W;

  typedef struct packed {
    logic              clkWr;
    logic [CODE_W-1:0] clkIdx;
    logic              biasWr;
    logic [BIDX_W-1:0] biasIdx;
    logic              ctrlWr;
    logic [VAL_W-1:0]  value;
  } dacStrobe_t;
endpackage

// File: rtl/bpDecodeCtrl.sv
module bpDecodeCtrl
  import bpDecodePkg::*;
#(
  parameter int TICK_CYCLES = 5,
  parameter int MAX_STEPS   = 250,
  parameter int N_CLK       = 12,
  parameter logic [SEL_W-1:0]  CTRL_CODE = 5'h1F,
  parameter logic [CODE_W-1:0] BIAS_CODE = 4'd12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrDelay,
  input  logic [15:0]      busData,
  input  logic             busA0,
  input  logic [SEL_W-1:0] cardAddr,
  output logic             waitOut,
  output dacStrobe_t       strobe
);
  localparam int MAX_CNT = MAX_STEPS * TICK_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0]  remCnt;
  logic              busy, acceptDelay, acceptWord, isCtrl, isCard;
  logic [SEL_W-1:0]  boardSel;
  logic [CODE_W-1:0] dacCode;
  logic [VAL_W-1:0]  stepsClamped;
  logic [CNT_W-1:0]  loadVal;
  logic              pending;
  logic [BIDX_W-1:0] pendIdx;

  assign busy        = (remCnt != '0);
  assign acceptDelay = wrEn && wrDelay && !busy;
  assign acceptWord  = wrEn && !wrDelay && !busy;
  assign boardSel    = {busData[15:12], busA0};
  assign dacCode     = busData[11:8];
  assign isCtrl      = acceptWord && (boardSel == CTRL_CODE);
  assign isCard      = acceptWord && (boardSel != CTRL_CODE) && (boardSel == cardAddr);
  assign waitOut     = busy || acceptDelay;

  always_comb begin
    if (busData[7:0] == '0)
      stepsClamped = 8'd1;
    else if (int'(busData[7:0]) > MAX_STEPS)
      stepsClamped = VAL_W'(MAX_STEPS);
    else
      stepsClamped = busData[7:0];
    loadVal = CNT_W'(int'(stepsClamped) * TICK_CYCLES - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      remCnt <= '0;
    else if (acceptDelay)
      remCnt <= loadVal;
    else if (busy)
      remCnt <= remCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendIdx <= '0;
    end else if (isCard) begin
      if (dacCode == BIAS_CODE) begin
        pending <= !pending;
        if (!pending) pendIdx <= busData[BIDX_W-1:0];
      end else begin
        pending <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.value  = busData[VAL_W-1:0];
    strobe.ctrlWr = isCtrl;
    if (isCard) begin
      if (dacCode == BIAS_CODE) begin
        strobe.biasWr  = pending;
        strobe.biasIdx = pendIdx;
      end else if (int'(dacCode) < N_CLK) begin
        strobe.clkWr  = 1'b1;
        strobe.clkIdx = dacCode;
      end
    end
  end

  assert_wait_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (remCnt == $past(remCnt) - 1'b1));

  assert_busy_no_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && wrDelay) |=> (remCnt == $past(remCnt) - 1'b1));

  assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptDelay |=> (remCnt == $past(loadVal)));
endmodule

// File: rtl/bpDecodeData.sv
module bpDecodeData
  import bpDecodePkg::*;
#(
  parameter int N_CLK = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dacStrobe_t               strobe,
  output logic [VAL_W-1:0]         ctrlLines,
  output logic [N_CLK*VAL_W-1:0]   clkDacBus,
  output logic [N_BIAS*BIAS_W-1:0] biasDacBus
);
  always_ff @(posedge clk) begin
    if (!rstN)             ctrlLines <= '0;
    else if (strobe.ctrlWr) ctrlLines <= strobe.value;
  end

  for (genvar k = 0; k < N_CLK; k++) begin : gClk
    always_ff @(posedge clk) begin
      if (!rstN)
        clkDacBus[k*VAL_W +: VAL_W] <= '0;
      else if (strobe.clkWr && (int'(strobe.clkIdx) == k))
        clkDacBus[k*VAL_W +: VAL_W] <= strobe.value;
    end
  end

  for (genvar j = 0; j < N_BIAS; j++) begin : gBias
    always_ff @(posedge clk) begin
      if (!rstN)
        biasDacBus[j*BIAS_W +: BIAS_W] <= '0;
      else if (strobe.biasWr && (int'(strobe.biasIdx) == j))
        biasDacBus[j*BIAS_W +: BIAS_W] <= {strobe.value, {PAD_W{1'b0}}};
    end
  end

  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clkWr, strobe.biasWr, strobe.ctrlWr}));

  assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlWr |=> (ctrlLines == $past(strobe.value)));

  assert_bias_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.biasWr |=> (biasDacBus[$past(strobe.biasIdx)*BIAS_W +: BIAS_W]
                       == {$past(strobe.value), {PAD_W{1'b0}}}));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clkWr || strobe.biasWr || strobe.ctrlWr)
      |=> ($stable(ctrlLines) && $stable(clkDacBus) && $stable(biasDacBus)));
endmodule

// File: rtl/bpTimingDecoder.sv
module bpTimingDecoder
  import bpDecodePkg::*;
#(
  parameter int TICK_CYCLES = 5,
  parameter int MAX_STEPS   = 250,
  parameter int N_CLK       = 12,
  parameter logic [SEL_W-1:0]  CTRL_CODE = 5'h1F,
  parameter logic [CODE_W-1:0] BIAS_CODE = 4'd12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     wrDelay,
  input  logic [15:0]              busData,
  input  logic                     busA0,
  input  logic [SEL_W-1:0]         cardAddr,
  output logic                     waitOut,
  output logic [VAL_W-1:0]         ctrlLines,
  output logic [N_CLK*VAL_W-1:0]   clkDacBus,
  output logic [N_BIAS*BIAS_W-1:0] biasDacBus
);
  dacStrobe_t strobe;

  bpDecodeCtrl #(
    .TICK_CYCLES(TICK_CYCLES), .MAX_STEPS(MAX_STEPS), .N_CLK(N_CLK),
    .CTRL_CODE(CTRL_CODE), .BIAS_CODE(BIAS_CODE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDelay(wrDelay),
    .busData(busData), .busA0(busA0), .cardAddr(cardAddr),
    .waitOut(waitOut), .strobe(strobe)
  );

  bpDecodeData #(.N_CLK(N_CLK)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ctrlLines(ctrlLines), .clkDacBus(clkDacBus), .biasDacBus(biasDacBus)
  );
endmodule

// File: tb/bpTimingDecoder_test.sv
`timescale 1ns/1ps
module bpTimingDecoder_test;
  localparam int TICK = 5;
  localparam logic [4:0] CARD = 5'h0A;

  logic clk = 0, rstN = 0, wrEn = 0, wrDelay = 0, busA0 = 0;
  logic [15:0] busData = '0;
  logic [4:0] cardAddr = CARD;
  logic waitOut;
  logic [7:0] ctrlLines;
  logic [95:0] clkDacBus, biasDacBus;

  bpTimingDecoder uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDelay(wrDelay),
    .busData(busData), .busA0(busA0), .cardAddr(cardAddr), .waitOut(waitOut),
    .ctrlLines(ctrlLines), .clkDacBus(clkDacBus), .biasDacBus(biasDacBus));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, waitLeft = 0;
  bit done = 0, expPend = 0;
  logic [2:0] expIdx = 0;
  logic [7:0] expCtrl = 0;
  logic [95:0] expClk = 0, expBias = 0;

  task automatic chk(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampSteps(logic [7:0] n);
    if (n == 0) return 1;
    if (n > 250) return 250;
    return int'(n);
  endfunction

  task automatic checkRegs(string tag);
    chk(ctrlLines == expCtrl, {tag, " ctrlLines"}, 96'(ctrlLines), 96'(expCtrl));
    chk(clkDacBus == expClk, {tag, " clkDacBus"}, clkDacBus, expClk);
    chk(biasDacBus == expBias, {tag, " biasDacBus"}, biasDacBus, expBias);
  endtask

  // one bus cycle: drive, check wait, update model, check registers after the edge
  task automatic step(bit we, bit dly, logic [15:0] d, bit a0, string tag);
    bit expW;
    logic [4:0] sel;
    logic [3:0] code;
    @(negedge clk);
    wrEn = we; wrDelay = dly; busData = d; busA0 = a0;
    #1;
    expW = (waitLeft > 0) || (we && dly);
    chk(waitOut == expW, {tag, " waitOut"}, 96'(waitOut), 96'(expW));
    sel = {d[15:12], a0}; code = d[11:8];
    if (waitLeft > 0) waitLeft--;
    else if (we && dly) waitLeft = clampSteps(d[7:0]) * TICK - 1;
    else if (we) begin
      if (sel == 5'h1F) expCtrl = d[7:0];
      else if (sel == CARD) begin
        if (code == 4'd12) begin
          if (expPend) expBias[int'(expIdx)*12 +: 12] = {d[7:0], 4'b0};
          else expIdx = d[2:0];
          expPend = !expPend;
        end else begin
          expPend = 0;
          if (code < 12) expClk[int'(code)*8 +: 8] = d[7:0];
        end
      end
    end
    @(posedge clk); #1;
    wrEn = 0; wrDelay = 0;
    checkRegs(tag);
  endtask

  function automatic logic [15:0] mkWord(logic [4:0] sel, logic [3:0] code, logic [7:0] v);
    return {sel[4:1], code, v};
  endfunction

  task automatic cardWr(logic [4:0] sel, logic [3:0] code, logic [7:0] v, string tag);
    step(1, 0, mkWord(sel, code, v), sel[0], tag);
  endtask

  task automatic drainWait(string tag);
    while (waitLeft > 0) step(0, 0, 16'h0, 0, tag);
  endtask

  task automatic delayRun(logic [7:0] n, string tag);
    int cnt = 0;
    step(1, 1, {8'h0, n}, 0, tag);
    cnt = 1;
    while (waitLeft > 0) begin step(0, 0, 16'h0, 0, tag); cnt++; end
    chk(cnt == clampSteps(n) * TICK, {tag, " wait length"}, 96'(cnt), 96'(clampSteps(n) * TICK));
    step(0, 0, 16'h0, 0, tag); // wait must now be low
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R1: reset state
    chk(waitOut == 0, "R1 waitOut", 96'(waitOut), 96'(0));
    checkRegs("R1");

    // R2: delay length and clamping
    delayRun(8'd3, "R2 n=3");
    delayRun(8'd0, "R2 n=0");
    delayRun(8'd250, "R2 n=250");
    delayRun(8'd255, "R2 n=255");

    // R3: words during stall ignored
    step(1, 1, 16'h0004, 0, "R3 start");
    cardWr(CARD, 4'd2, 8'h55, "R3 card word in stall");
    step(1, 0, mkWord(5'h1F, 0, 8'hAA), 1, "R3 ctrl word in stall");
    step(1, 1, 16'h00F0, 0, "R3 delay in stall");
    drainWait("R3 drain");

    // R5: intercept
    cardWr(5'h1F, 4'd0, 8'hC3, "R5 ctrl");
    // R6: clock DACs at both ends
    cardWr(CARD, 4'd0, 8'h11, "R6 clk0");
    cardWr(CARD, 4'd11, 8'hFF, "R6 clk11");
    // R4: foreign board
    cardWr(5'h0B, 4'd3, 8'h77, "R4 other board");
    // R7/R8: bias sequence
    cardWr(CARD, 4'd12, 8'h05, "R7 bias step1");
    cardWr(CARD, 4'd12, 8'hAB, "R8 bias step2");
    // R10: pending survives delay, ctrl, foreign word
    cardWr(CARD, 4'd12, 8'h07, "R10 step1");
    step(1, 1, 16'h0002, 0, "R10 delay");
    drainWait("R10 drain");
    cardWr(5'h1F, 4'd5, 8'h3C, "R10 ctrl");
    cardWr(5'h03, 4'd12, 8'h99, "R10 foreign bias");
    cardWr(CARD, 4'd12, 8'hE1, "R10 step2");
    // R9: cancel by code 14 and by clock code
    cardWr(CARD, 4'd12, 8'h02, "R9 step1");
    cardWr(CARD, 4'd14, 8'h44, "R9 cancel code14");
    cardWr(CARD, 4'd12, 8'h06, "R9 new step1 no write");
    cardWr(CARD, 4'd4, 8'h66, "R9 cancel clk");
    cardWr(CARD, 4'd12, 8'h01, "R9 step1 again");
    cardWr(CARD, 4'd12, 8'h5A, "R8 step2 after cancel");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [4:0] sel;
      logic [3:0] code;
      if (r < 5) step(1, 1, {8'h0, 8'($urandom_range(0, 6))}, 0, "R2 rnd delay");
      else if (r < 10) step(0, 0, 16'($urandom), 0, "R3 rnd idle");
      else begin
        r = $urandom_range(0, 99);
        sel = (r < 55) ? CARD : (r < 70) ? 5'h1F : 5'($urandom);
        code = ($urandom_range(0, 2) == 0) ? 4'd12 : 4'($urandom);
        cardWr(sel, code, 8'($urandom), "R4 R5 R6 R8 R9 rnd");
      end
    end
    drainWait("R2 final");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule